// File: doc/BRIEF.md
# Tag Compare Match Unit

This block sits beside a synchronous word memory and serves cache tag lookups as well as plain reads and writes. A compare cycle is issued like a read, but the data bus is not driven. The compare value enters through the data-input register in the same clock edge that reads the addressed word. The stored word and the captured value are then compared, and the result is a match flag.

The same mode input selects when both the read data and the match flag appear. In flow-through mode they appear after the first rising edge following the issue. In pipelined mode each passes through an extra output register and appears one edge later. The data bus drive enable and the match output each have their own asynchronous output enable. A disabled match output reads as inactive, and a separate valid flag models the high-impedance state. A synchronous capture enable decides whether the data-input register takes the bus or keeps its old value. The held value then serves both compares and writes.

A parameter mask can drop bits that do not belong to the tag from the comparison. The memory is a byte-lane RAM model held inside the project.

Top module: `tag_match_unit`

## Requirements
- R1: While reset is high and after it, until a new cycle reaches the outputs, `dout_drive`, `match_valid` and `match_out` are 0.
- R2: A write (`cyc_op` = 2'b01) stores the effective data into the lanes selected by `byte_en`. Bit 0 selects bits [8:0] and bit 1 selects bits [17:9]. A later read returns the merged word. A write cycle drives neither the bus nor the match output.
- R3: A read (`cyc_op` = 2'b00) places the stored word on `dout` with `dout_drive` high. With `pipe_mode` = 0 this happens after the first rising edge following the issue. With `pipe_mode` = 1 it happens after the second edge, and the outputs are inactive after the first.
- R4: A compare (`cyc_op` = 2'b10) raises `match_valid`. `match_out` is 1 exactly when (stored word XOR effective compare value) AND `CMP_MASK` is zero.
- R5: The match flag follows the same latency as R3: one edge in flow-through mode, two edges in pipelined mode.
- R6: `dout_drive` stays 0 in both the flow-through and pipelined data phases of a compare cycle.
- R7: `dout_oe` low forces `dout_drive` to 0 without waiting for a clock edge. Raising it again restores the drive at once.
- R8: `match_oe` low forces `match_valid` and `match_out` to 0 without waiting for a clock edge. Raising it again brings the flag back at once.
- R9: When `din_cap_en` is 0 on an edge, the data-input register keeps its value. A compare then uses the held value, and a write stores the held value.
- R10: Bits at 0 in `CMP_MASK` have no effect on `match_out`.
- R11: An idle edge (`cyc_valid` = 0) or the spare code 2'b11 leaves memory unchanged and produces no drive and no match valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined outputs, 0 = flow-through |
| cyc_valid | input | 1 | A cycle is issued on this edge |
| cyc_op | input | 2 | 00 read, 01 write, 10 compare, 11 spare (no-op) |
| cyc_addr | input | AW | Word address |
| byte_en | input | NB | Write lane enables |
| din_cap_en | input | 1 | Data-input register capture enable |
| din | input | DW | Data / compare bus in |
| dout_oe | input | 1 | Asynchronous data drive enable |
| match_oe | input | 1 | Asynchronous match output enable |
| dout | output | DW | Read data |
| dout_drive | output | 1 | Data bus drive enable |
| match_out | output | 1 | Match flag |
| match_valid | output | 1 | Match output enabled and carrying a compare result |

## Verification
The bench builds the unit with a 64-word memory (AW = 6) and `CMP_MASK` = 18'h3FFF0, so the four low bits are excluded from the tag. The small depth lets random traffic hit each address repeatedly, which exercises partial-lane merges and compares against freshly written words. The mask lets compare values that differ only in the excluded bits be shown to still match, while a one-bit change in bit 4 must miss. Both values of `pipe_mode` are run, so the latency checks cover both output paths.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_CMP   = 2'b10,
    OP_SPARE = 2'b11
  } tmu_op_e;
endpackage

// File: rtl/tmu_ram.sv
// Byte-lane RAM with a registered read port; one array per lane so
// block RAM with lane enables can be inferred.
module tmu_ram #(
  parameter int DW = 18,
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic [NB-1:0] we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int BW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  for (genvar gl = 0; gl < NB; gl++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] q;
    always_ff @(posedge clk) begin
      if (we[gl]) mem[addr] <= wdata[gl*BW +: BW];
      if (re)     q <= mem[addr];
    end
    assign rdata[gl*BW +: BW] = q;
  end
endmodule

// File: rtl/tmu_din_reg.sv
// Data-input register with synchronous capture enable.
module tmu_din_reg #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] held,
  output logic [DW-1:0] eff
);
  assign eff = cap_en ? bus : held;

  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (cap_en) held <= bus;
  end
endmodule

// File: rtl/tmu_cmp.sv
// Masked equality comparator.
module tmu_cmp #(
  parameter int          DW   = 18,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] key,
  output logic          hit
);
  logic [DW-1:0] diff;
  assign diff = (word ^ key) & MASK;
  assign hit  = (diff == '0);
endmodule

// File: rtl/tmu_out_stage.sv
// Optional output register for data and match, chosen by pipe_mode.
module tmu_out_stage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic          f_rd_act,
  input  logic [DW-1:0] f_data,
  input  logic          f_cmp_act,
  input  logic          f_hit,
  output logic          o_rd_act,
  output logic [DW-1:0] o_data,
  output logic          o_cmp_act,
  output logic          o_hit
);
  logic          p_rd_act, p_cmp_act, p_hit;
  logic [DW-1:0] p_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_rd_act  <= 1'b0;
      p_cmp_act <= 1'b0;
      p_hit     <= 1'b0;
    end else begin
      p_rd_act  <= f_rd_act;
      p_cmp_act <= f_cmp_act;
      p_hit     <= f_hit;
    end
  end

  always_ff @(posedge clk) p_data <= f_data;

  always_comb begin
    if (pipe_mode) begin
      o_rd_act  = p_rd_act;
      o_data    = p_data;
      o_cmp_act = p_cmp_act;
      o_hit     = p_hit;
    end else begin
      o_rd_act  = f_rd_act;
      o_data    = f_data;
      o_cmp_act = f_cmp_act;
      o_hit     = f_hit;
    end
  end
endmodule

// File: rtl/tag_match_unit.sv
module tag_match_unit
  import tmu_pkg::*;
#(
  parameter int            DW       = 18,
  parameter int            AW       = 8,
  parameter int            NB       = 2,
  parameter logic [DW-1:0] CMP_MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_mode,
  input  logic          cyc_valid,
  input  logic [1:0]    cyc_op,
  input  logic [AW-1:0] cyc_addr,
  input  logic [NB-1:0] byte_en,
  input  logic          din_cap_en,
  input  logic [DW-1:0] din,
  input  logic          dout_oe,
  input  logic          match_oe,
  output logic [DW-1:0] dout,
  output logic          dout_drive,
  output logic          match_out,
  output logic          match_valid
);
  tmu_op_e op;
  logic    is_rd, is_wr, is_cmp;
  assign op     = tmu_op_e'(cyc_op);
  assign is_rd  = cyc_valid && (op == OP_READ);
  assign is_wr  = cyc_valid && (op == OP_WRITE);
  assign is_cmp = cyc_valid && (op == OP_CMP);

  // data-input register
  logic [DW-1:0] key_q, wr_data;
  tmu_din_reg #(.DW(DW)) u_din (
    .clk(clk), .rst(rst), .cap_en(din_cap_en), .bus(din),
    .held(key_q), .eff(wr_data)
  );

  // memory
  logic [DW-1:0] rd_word;
  tmu_ram #(.DW(DW), .AW(AW), .NB(NB)) u_ram (
    .clk(clk), .we(is_wr ? byte_en : '0), .re(is_rd || is_cmp),
    .addr(cyc_addr), .wdata(wr_data), .rdata(rd_word)
  );

  // stage-1 cycle type
  logic s1_rd, s1_cmp;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd  <= 1'b0;
      s1_cmp <= 1'b0;
    end else begin
      s1_rd  <= is_rd;
      s1_cmp <= is_cmp;
    end
  end

  // comparator
  logic hit_f;
  tmu_cmp #(.DW(DW), .MASK(CMP_MASK)) u_cmp (
    .word(rd_word), .key(key_q), .hit(hit_f)
  );

  // output stage
  logic o_rd, o_cmp, o_hit;
  tmu_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode),
    .f_rd_act(s1_rd), .f_data(rd_word), .f_cmp_act(s1_cmp), .f_hit(hit_f),
    .o_rd_act(o_rd), .o_data(dout), .o_cmp_act(o_cmp), .o_hit(o_hit)
  );

  assign dout_drive  = o_rd && dout_oe;
  assign match_valid = o_cmp && match_oe;
  assign match_out   = match_valid && o_hit;
endmodule

// File: rtl/tmu_checker.sv
module tmu_checker (
  input logic       clk,
  input logic       rst,
  input logic       pipe_mode,
  input logic       cyc_valid,
  input logic [1:0] cyc_op,
  input logic       dout_oe,
  input logic       match_oe,
  input logic       dout_drive,
  input logic       match_valid,
  input logic       match_out
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!dout_drive && !match_valid));

  p_flow_nonread_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_op != 2'b00 && !pipe_mode) |=> (pipe_mode || !dout_drive));

  p_cmp_flow_nodrive_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_op == 2'b10 && !pipe_mode) |=> (pipe_mode || !dout_drive));

  p_cmp_pipe_nodrive_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_op == 2'b10 && pipe_mode) |=> ##1 (!pipe_mode || !dout_drive));

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout_drive);

  p_moe_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !match_oe |-> (!match_valid && !match_out));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!cyc_valid && !pipe_mode) |=> (pipe_mode || (!dout_drive && !match_valid)));
endmodule

bind tag_match_unit tmu_checker u_tmu_checker (
  .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .cyc_valid(cyc_valid),
  .cyc_op(cyc_op), .dout_oe(dout_oe), .match_oe(match_oe),
  .dout_drive(dout_drive), .match_valid(match_valid), .match_out(match_out)
);

// File: tb/tag_match_unit_bench.sv
module tag_match_unit_bench;
  localparam int            DW   = 18;
  localparam int            AW   = 6;
  localparam int            NB   = 2;
  localparam logic [DW-1:0] MASK = 18'h3FFF0;
  localparam int            DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pipe_mode = 1'b0;
  logic          cyc_valid = 1'b0;
  logic [1:0]    cyc_op = 2'b00;
  logic [AW-1:0] cyc_addr = '0;
  logic [NB-1:0] byte_en = '0;
  logic          din_cap_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic          dout_oe = 1'b1;
  logic          match_oe = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_drive, match_out, match_valid;

  tag_match_unit #(.DW(DW), .AW(AW), .NB(NB), .CMP_MASK(MASK)) u_tag_match_unit (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .cyc_valid(cyc_valid),
    .cyc_op(cyc_op), .cyc_addr(cyc_addr), .byte_en(byte_en),
    .din_cap_en(din_cap_en), .din(din), .dout_oe(dout_oe), .match_oe(match_oe),
    .dout(dout), .dout_drive(dout_drive), .match_out(match_out),
    .match_valid(match_valid)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] held_m = '0;

  function automatic logic exp_hit(input logic [DW-1:0] w, input logic [DW-1:0] k);
    return ((w ^ k) & MASK) == '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle from a negedge; returns at the following negedge, idle
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [1:0] be, input logic cap);
    logic [DW-1:0] eff;
    eff = cap ? d : held_m;
    cyc_valid = 1'b1; cyc_op = op; cyc_addr = a; din = d;
    byte_en = be; din_cap_en = cap;
    @(posedge clk);
    @(negedge clk);
    cyc_valid = 1'b0; din_cap_en = 1'b0; byte_en = '0;
    if (op == 2'b01) begin
      if (be[0]) mem_m[a][8:0]  = eff[8:0];
      if (be[1]) mem_m[a][17:9] = eff[17:9];
    end
    if (cap) held_m = d;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] be, input logic cap);
    logic [DW-1:0] word, key;
    word = mem_m[a];
    key  = cap ? d : held_m;
    issue(op, a, d, be, cap);
    if (pipe_mode) begin
      chk("R3 pipelined data not early", {31'd0, dout_drive}, 32'd0);
      chk("R5 pipelined match not early", {31'd0, match_valid}, 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    case (op)
      2'b00: begin
        chk("R3 read drive", {31'd0, dout_drive}, 32'd1);
        chk("R3 read data", {14'd0, dout}, {14'd0, word});
        chk("R3 read no match", {31'd0, match_valid}, 32'd0);
      end
      2'b10: begin
        chk("R6 compare no drive", {31'd0, dout_drive}, 32'd0);
        chk("R5 compare valid", {31'd0, match_valid}, 32'd1);
        chk("R4 compare result", {31'd0, match_out}, {31'd0, exp_hit(word, key)});
      end
      2'b01: begin
        chk("R2 write quiet drive", {31'd0, dout_drive}, 32'd0);
        chk("R2 write quiet match", {31'd0, match_valid}, 32'd0);
      end
      default: begin
        chk("R11 spare quiet drive", {31'd0, dout_drive}, 32'd0);
        chk("R11 spare quiet match", {31'd0, match_valid}, 32'd0);
      end
    endcase
  endtask

  task automatic set_mode(input logic m);
    repeat (3) @(negedge clk);
    pipe_mode = m;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] v;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset drive", {31'd0, dout_drive}, 32'd0);
    chk("R1 reset match valid", {31'd0, match_valid}, 32'd0);
    chk("R1 reset match out", {31'd0, match_out}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset drive", {31'd0, dout_drive}, 32'd0);

    // fill memory (R2)
    for (int i = 0; i < DEPTH; i++) issue(2'b01, AW'(i), DW'($urandom), 2'b11, 1'b1);

    // random traffic in both modes
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int n = 0; n < 300; n++) begin
        int sel;
        logic cap;
        a   = AW'($urandom);
        sel = int'($urandom % 8);
        cap = ($urandom % 4) != 0;
        case (sel)
          0, 1: run_op(2'b00, a, DW'($urandom), 2'b00, cap);
          2:    run_op(2'b01, a, DW'($urandom), 2'($urandom), cap);
          3:    run_op(2'b10, a, mem_m[a], 2'b00, 1'b1);
          4:    run_op(2'b10, a, mem_m[a] ^ DW'($urandom % 16), 2'b00, 1'b1);
          5:    run_op(2'b10, a, DW'($urandom), 2'b00, cap);
          6:    run_op(2'b11, a, DW'($urandom), 2'b11, cap);
          default: run_op(2'b10, a, mem_m[a] ^ (DW'(1) << (4 + $urandom % 14)), 2'b00, 1'b1);
        endcase
      end
    end

    // R2: partial-lane merge, directed
    set_mode(1'b0);
    run_op(2'b01, 6'd5, 18'h3FFFF, 2'b11, 1'b1);
    run_op(2'b01, 6'd5, 18'h00000, 2'b01, 1'b1);
    run_op(2'b00, 6'd5, 18'h0, 2'b00, 1'b0);
    chk("R2 low lane cleared", {14'd0, dout}, {14'd0, 18'h3FE00});

    // R7: asynchronous data enable
    dout_oe = 1'b0;
    issue(2'b00, 6'd5, 18'h0, 2'b00, 1'b0);
    chk("R7 oe low blocks drive", {31'd0, dout_drive}, 32'd0);
    dout_oe = 1'b1;
    #1;
    chk("R7 oe raised drives", {31'd0, dout_drive}, 32'd1);
    @(negedge clk);

    // R8: asynchronous match enable
    match_oe = 1'b0;
    issue(2'b10, 6'd5, 18'h3FE00, 2'b00, 1'b1);
    chk("R8 moe low valid", {31'd0, match_valid}, 32'd0);
    chk("R8 moe low out", {31'd0, match_out}, 32'd0);
    match_oe = 1'b1;
    #1;
    chk("R8 moe raised valid", {31'd0, match_valid}, 32'd1);
    chk("R8 moe raised out", {31'd0, match_out}, 32'd1);
    @(negedge clk);

    // R10: masked bits ignored, bit 4 counts
    run_op(2'b10, 6'd5, 18'h3FE0F, 2'b00, 1'b1);
    chk("R10 masked diff matches", {31'd0, match_out}, 32'd1);
    run_op(2'b10, 6'd5, 18'h3FE10, 2'b00, 1'b1);
    chk("R10 bit4 diff misses", {31'd0, match_out}, 32'd0);

    // R9: held compare value and held write data
    v = mem_m[6'd9];
    run_op(2'b10, 6'd9, v, 2'b00, 1'b1);
    run_op(2'b10, 6'd9, ~v, 2'b00, 1'b0);
    chk("R9 held key matches", {31'd0, match_out}, 32'd1);
    run_op(2'b01, 6'd10, 18'h0, 2'b11, 1'b0);
    run_op(2'b00, 6'd10, 18'h0, 2'b00, 1'b0);
    chk("R9 write uses held data", {14'd0, dout}, {14'd0, v});

    // R11: spare op leaves memory alone
    v = mem_m[6'd11];
    run_op(2'b11, 6'd11, ~v, 2'b11, 1'b1);
    run_op(2'b00, 6'd11, 18'h0, 2'b00, 1'b0);
    chk("R11 memory unchanged", {14'd0, dout}, {14'd0, v});

    // R5/R3 in pipelined mode, directed
    set_mode(1'b1);
    run_op(2'b10, 6'd11, v, 2'b00, 1'b1);
    chk("R5 pipelined match", {31'd0, match_out}, 32'd1);
    run_op(2'b00, 6'd11, 18'h0, 2'b00, 1'b0);
    chk("R3 pipelined read", {14'd0, dout}, {14'd0, v});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule